// File: doc/BRIEF.md
# Low-Power State Controller

This block sequences the two software-requested sleep states of a small 8-bit controller core. A write to the power-control bits moves the core from normal running into either a light sleep, where only the processor clock is held off and the peripherals keep their clock, or a deep sleep, where the oscillator itself is switched off. The block decides how each state is left. It also decides how the register reset, the RAM write protection and the overrides on the external strobes and address/data ports behave in every state.

Light sleep ends on any enabled interrupt or on a hardware reset. Deep sleep ends only on a hardware reset. When a reset arrives during light sleep, the core keeps executing for a short window before the reset takes hold. During that window, writes to internal RAM are blocked and port writes are still allowed. When a reset ends deep sleep, the oscillator runs again at once. The reset must then stay asserted for a set number of cycles so that the oscillator can settle, and only then is the core released. In every reset state the special-function registers are reset and RAM is protected, so RAM contents survive.

Top module: `lpm_ctrl`

## Requirements
- R1: In the running state, a write with `req_idle`=1 and `req_pdown`=0 enters light sleep on the next clock edge: `cpu_clk_en`=0, `osc_en`=1.
- R2: In the running state, a write with `req_pdown`=1 enters deep sleep on the next edge, whatever the value of `req_idle`: `osc_en`=0, `cpu_clk_en`=0.
- R3: Running outputs are `cpu_clk_en`=1, `osc_en`=1, `ram_wr_inh`=0, `sfr_rst`=0, `pin_force`=0, with `ale_lvl`, `psen_lvl`, `p0_float` and `p2_addr` all 0. `hw_rst` in the running state takes priority over a write and gives `sfr_rst`=1 on the next edge. Writes are ignored in every state other than running.
- R4: In light sleep, `irq_pend` with `hw_rst`=0 returns the block to running on the next edge (`cpu_clk_en`=1, `pin_force`=0).
- R5: In light sleep, `hw_rst`=1 starts a window of exactly WIN_CYC cycles with `cpu_clk_en`=1, `ram_wr_inh`=1, `sfr_rst`=0 and `pin_force`=0. After the window, `sfr_rst`=1 until a cycle with `hw_rst`=0, and then running on the next edge.
- R6: Deep sleep ignores `irq_pend` and writes. It remains in place while `hw_rst`=0.
- R7: In deep sleep, `hw_rst`=1 gives `osc_en`=1, `sfr_rst`=1 and `cpu_clk_en`=0 on the next edge. The core reaches running on the edge after `hw_rst` falls only if `hw_rst` was high for at least WARM_CYC cycles in this warm-up state. A shorter reset returns the block to deep sleep.
- R8: `ram_wr_inh`=1 whenever `sfr_rst`=1.
- R9: Light-sleep pins: `pin_force`=1, `ale_lvl`=1, `psen_lvl`=1, `p0_float`=`ext_prog`, `p2_addr`=`ext_prog`.
- R10: Deep-sleep pins: `pin_force`=1, `ale_lvl`=0, `psen_lvl`=0, `p0_float`=`ext_prog`, `p2_addr`=0.
- R11: While `rst_n` is low, the block sits in the reset state: `sfr_rst`=1, `ram_wr_inh`=1, `cpu_clk_en`=1, `osc_en`=1, `pin_force`=0. It goes to running one edge after `hw_rst` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_rst | input | 1 | Synchronous hardware reset request, active high |
| pcon_wr | input | 1 | Write strobe for the power-control bits |
| req_idle | input | 1 | Light-sleep request bit of the write |
| req_pdown | input | 1 | Deep-sleep request bit of the write |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_prog | input | 1 | 1 = program runs from external memory |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inh | output | 1 | Blocks internal RAM writes |
| sfr_rst | output | 1 | Resets special-function registers |
| pin_force | output | 1 | Sleep pin overrides are active |
| ale_lvl | output | 1 | Forced level of the address-latch strobe |
| psen_lvl | output | 1 | Forced level of the program-read strobe |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr | output | 1 | Port 2 drives the high address byte |

## Verification
On every cycle, the assertions check the entry edges into both sleep states, the priority of deep over light sleep, interrupt wake-up, the start of the reset window, that deep sleep holds while `hw_rst` is low, the pin tables of both sleep states and the coupling of `sfr_rst` to RAM protection. Two things need the bench's scenarios because they depend on counted durations: the exact length of the light-sleep reset window and the warm-up rule, where a short reset falls back to deep sleep and a long one releases the core. A random phase with a sticky reset input mixes all transitions against a bench model of the six states.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_PD   = 3'd2,
    ST_WIN  = 3'd3,
    ST_RST  = 3'd4,
    ST_WARM = 3'd5
  } lpm_state_e;
endpackage

// File: rtl/lpm_cnt.sv
module lpm_cnt #(
  parameter int MAXV = 64,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(MAXV);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)             cnt_d = '0;
    else if (inc && cnt != TOP) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int WIN_CYC  = 24,
  parameter int WARM_CYC = 64,
  parameter int CW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_rst,
  input  logic          irq_pend,
  input  logic          pcon_wr,
  input  logic          req_idle,
  input  logic          req_pdown,
  input  logic [CW-1:0] cnt,
  output lpm_state_e    state
);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] WARM_MIN = CW'(WARM_CYC);
  lpm_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RUN: begin
        if (hw_rst)                      state_d = ST_RST;
        else if (pcon_wr && req_pdown)   state_d = ST_PD;
        else if (pcon_wr && req_idle)    state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (hw_rst)        state_d = ST_WIN;
        else if (irq_pend) state_d = ST_RUN;
      end
      ST_PD:   if (hw_rst) state_d = ST_WARM;
      ST_WIN:  if (cnt == WIN_LAST) state_d = ST_RST;
      ST_RST:  if (!hw_rst) state_d = ST_RUN;
      ST_WARM: if (!hw_rst) state_d = (cnt >= WARM_MIN) ? ST_RUN : ST_PD;
      default: state_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RST;
    else        state <= state_d;
  end
endmodule

// File: rtl/lpm_pins.sv
module lpm_pins
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       ext_prog,
  output logic       cpu_clk_en,
  output logic       osc_en,
  output logic       ram_wr_inh,
  output logic       sfr_rst,
  output logic       pin_force,
  output logic       ale_lvl,
  output logic       psen_lvl,
  output logic       p0_float,
  output logic       p2_addr
);
  always_comb begin
    cpu_clk_en = 1'b1;
    osc_en     = 1'b1;
    ram_wr_inh = 1'b0;
    sfr_rst    = 1'b0;
    pin_force  = 1'b0;
    ale_lvl    = 1'b0;
    psen_lvl   = 1'b0;
    p0_float   = 1'b0;
    p2_addr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpu_clk_en = 1'b0;
        pin_force  = 1'b1;
        ale_lvl    = 1'b1;
        psen_lvl   = 1'b1;
        p0_float   = ext_prog;
        p2_addr    = ext_prog;
      end
      ST_PD: begin
        cpu_clk_en = 1'b0;
        osc_en     = 1'b0;
        pin_force  = 1'b1;
        p0_float   = ext_prog;
      end
      ST_WIN:  ram_wr_inh = 1'b1;
      ST_RST: begin
        ram_wr_inh = 1'b1;
        sfr_rst    = 1'b1;
      end
      ST_WARM: begin
        cpu_clk_en = 1'b0;
        ram_wr_inh = 1'b1;
        sfr_rst    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int WIN_CYC  = 24,
  parameter int WARM_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic pcon_wr,
  input  logic req_idle,
  input  logic req_pdown,
  input  logic irq_pend,
  input  logic ext_prog,
  output logic cpu_clk_en,
  output logic osc_en,
  output logic ram_wr_inh,
  output logic sfr_rst,
  output logic pin_force,
  output logic ale_lvl,
  output logic psen_lvl,
  output logic p0_float,
  output logic p2_addr
);
  localparam int MAXV = (WIN_CYC > WARM_CYC) ? WIN_CYC : WARM_CYC;
  localparam int CW   = $clog2(MAXV + 1);

  logic [1:0]    rsync;
  logic          rst_n_s;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_inc;
  lpm_state_e    state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_n_s = rsync[1];

  assign cnt_clr = (state != ST_WIN) && (state != ST_WARM);
  assign cnt_inc = (state == ST_WIN) || (state == ST_WARM && hw_rst);

  lpm_cnt #(.MAXV(MAXV)) i_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  lpm_fsm #(.WIN_CYC(WIN_CYC), .WARM_CYC(WARM_CYC), .CW(CW)) i_fsm (
    .clk(clk), .rst_n(rst_n_s), .hw_rst(hw_rst), .irq_pend(irq_pend),
    .pcon_wr(pcon_wr), .req_idle(req_idle), .req_pdown(req_pdown),
    .cnt(cnt), .state(state)
  );

  lpm_pins i_pins (
    .state(state), .ext_prog(ext_prog),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .ram_wr_inh(ram_wr_inh),
    .sfr_rst(sfr_rst), .pin_force(pin_force), .ale_lvl(ale_lvl),
    .psen_lvl(psen_lvl), .p0_float(p0_float), .p2_addr(p2_addr)
  );
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk (
  input logic clk,
  input logic rst_n,
  input logic hw_rst,
  input logic pcon_wr,
  input logic req_idle,
  input logic req_pdown,
  input logic irq_pend,
  input logic ext_prog,
  input logic cpu_clk_en,
  input logic osc_en,
  input logic ram_wr_inh,
  input logic sfr_rst,
  input logic pin_force,
  input logic ale_lvl,
  input logic psen_lvl,
  input logic p0_float,
  input logic p2_addr
);
  logic running, light, deep;
  assign running = cpu_clk_en && !ram_wr_inh && !sfr_rst;
  assign light   = pin_force && osc_en;
  assign deep    = !osc_en;

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    running && !hw_rst && pcon_wr && req_idle && !req_pdown |=> !cpu_clk_en && osc_en); // R1
  AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    running && !hw_rst && pcon_wr && req_pdown |=> !osc_en && !cpu_clk_en); // R2
  AST_RST_BEATS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    running && hw_rst |=> sfr_rst); // R3
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    light && irq_pend && !hw_rst |=> cpu_clk_en && !pin_force && !ram_wr_inh); // R4
  AST_WIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    light && hw_rst |=> cpu_clk_en && ram_wr_inh && !sfr_rst && !pin_force); // R5
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    deep && !hw_rst |=> deep); // R6
  AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    deep && hw_rst |=> osc_en && sfr_rst && !cpu_clk_en); // R7
  AST_RAM_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rst |-> ram_wr_inh); // R8
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    light |-> ale_lvl && psen_lvl && p0_float == ext_prog && p2_addr == ext_prog); // R9
  AST_PD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> pin_force && !ale_lvl && !psen_lvl && p0_float == ext_prog && !p2_addr); // R10
endmodule

bind lpm_ctrl lpm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pcon_wr(pcon_wr),
  .req_idle(req_idle), .req_pdown(req_pdown), .irq_pend(irq_pend),
  .ext_prog(ext_prog), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
  .ram_wr_inh(ram_wr_inh), .sfr_rst(sfr_rst), .pin_force(pin_force),
  .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float), .p2_addr(p2_addr)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  localparam int WIN  = 6;
  localparam int WARM = 20;
  localparam int M_RUN = 0, M_IDLE = 1, M_PD = 2, M_WIN = 3, M_RST = 4, M_WARM = 5;

  logic clk = 1'b0;
  logic rst_n, hw_rst, pcon_wr, req_idle, req_pdown, irq_pend, ext_prog;
  logic cpu_clk_en, osc_en, ram_wr_inh, sfr_rst, pin_force, ale_lvl, psen_lvl, p0_float, p2_addr;

  int total = 0, bad = 0;
  int mst, mcnt;

  always #4 clk = ~clk;

  lpm_ctrl #(.WIN_CYC(WIN), .WARM_CYC(WARM)) i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .pcon_wr(pcon_wr),
    .req_idle(req_idle), .req_pdown(req_pdown), .irq_pend(irq_pend),
    .ext_prog(ext_prog), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .ram_wr_inh(ram_wr_inh), .sfr_rst(sfr_rst), .pin_force(pin_force),
    .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float), .p2_addr(p2_addr)
  );

  // {cpu, osc, inh, sfr, force, ale, psen, p0f, p2a}
  function automatic logic [8:0] exp_out(int st, logic ext);
    case (st)
      M_RUN:   return 9'b110000000;
      M_IDLE:  return {7'b0100111, ext, ext};
      M_PD:    return {7'b0000100, ext, 1'b0};
      M_WIN:   return 9'b111000000;
      M_RST:   return 9'b111100000;
      default: return 9'b011100000;
    endcase
  endfunction

  function automatic string st_tag(int st);
    case (st)
      M_RUN: return "R3"; M_IDLE: return "R9"; M_PD: return "R10";
      M_WIN: return "R5"; M_RST: return "R11"; default: return "R7";
    endcase
  endfunction

  task automatic model(logic hw, logic wr, logic idl, logic pd, logic irq);
    case (mst)
      M_RUN:  if (hw) mst = M_RST; else if (wr && pd) mst = M_PD; else if (wr && idl) mst = M_IDLE;
      M_IDLE: if (hw) begin mst = M_WIN; mcnt = 0; end else if (irq) mst = M_RUN;
      M_PD:   if (hw) begin mst = M_WARM; mcnt = 0; end
      M_WIN:  if (mcnt == WIN - 1) mst = M_RST; else mcnt++;
      M_RST:  if (!hw) mst = M_RUN;
      default: if (!hw) mst = (mcnt >= WARM) ? M_RUN : M_PD; else if (mcnt < WARM) mcnt++;
    endcase
  endtask

  task automatic check(string tag);
    logic [8:0] act, exp;
    act = {cpu_clk_en, osc_en, ram_wr_inh, sfr_rst, pin_force, ale_lvl, psen_lvl, p0_float, p2_addr};
    exp = exp_out(mst, ext_prog);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs=%b expected=%b (t=%0t)", (tag == "") ? st_tag(mst) : tag, act, exp, $time);
    end
  endtask

  task automatic step(logic hw, logic wr, logic idl, logic pd, logic irq, logic ext, string tag);
    hw_rst = hw; pcon_wr = wr; req_idle = idl; req_pdown = pd; irq_pend = irq; ext_prog = ext;
    @(posedge clk);
    if (rst_n) model(hw, wr, idl, pd, irq);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected end before limit");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic hw_r, ext_r;
    void'($urandom(32'd2024));
    rst_n = 1'b0; hw_rst = 1'b1; pcon_wr = 0; req_idle = 0; req_pdown = 0; irq_pend = 0; ext_prog = 0;
    mst = M_RST; mcnt = 0;
    repeat (3) @(negedge clk);
    check("R11 reset state");
    rst_n = 1'b1;
    repeat (4) step(1, 0, 0, 0, 0, 0, "R11 hold");
    step(0, 0, 0, 0, 0, 0, "R11 release");
    // light sleep, external program memory, then interrupt wake
    step(0, 1, 1, 0, 0, 1, "R1 idle entry");
    step(0, 0, 0, 0, 0, 1, "R9 idle pins ext");
    step(0, 0, 0, 0, 0, 0, "R9 idle pins int");
    step(0, 1, 0, 1, 0, 0, "R3 write ignored in idle");
    step(0, 0, 0, 0, 1, 0, "R4 irq wake");
    // both bits: deep sleep wins
    step(0, 1, 1, 1, 0, 1, "R2 pd wins");
    step(0, 1, 1, 0, 1, 1, "R6 irq/write ignored");
    step(0, 0, 0, 0, 1, 0, "R10 pd pins");
    // short reset falls back to deep sleep
    for (int i = 0; i < WARM - 5; i++) step(1, 0, 0, 0, 0, 0, "R7 warm");
    step(0, 0, 0, 0, 0, 0, "R7 short reset");
    step(0, 0, 0, 0, 0, 0, "R7 back to pd");
    for (int i = 0; i < WARM + 2; i++) step(1, 0, 0, 0, 0, 0, "R8 warm");
    step(0, 0, 0, 0, 0, 0, "R7 long reset release");
    // reset during light sleep: window then reset
    step(0, 1, 1, 0, 0, 0, "R1 idle entry");
    for (int i = 0; i < WIN + 3; i++) step(1, 0, 0, 0, 0, 0, "R5 window");
    step(0, 0, 0, 0, 0, 0, "R5 release");
    step(1, 1, 0, 1, 0, 0, "R3 reset beats write");
    step(0, 0, 0, 0, 0, 0, "R3 run again");
    // random phase
    hw_r = 0; ext_r = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 24 == 0) hw_r = ~hw_r;
      if ($urandom % 50 == 0) ext_r = ~ext_r;
      step(hw_r, ($urandom % 4) == 0, 1'($urandom), 1'($urandom), ($urandom % 8) == 0, ext_r, "");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule